// File: doc/BRIEF.md
# Open-Drain Bus Arbitration Guard

This block sits between a two-wire bus master's bit sequencer and the open-drain pads for the clock and data lines. The sequencer asks for a level on each line. The block never drives a line high. A requested 1 turns the pad's low driver off and lets the pull-up win. A requested 0 turns the low driver on.

Several masters may share the bus, so the block watches the data line for a lost arbitration. Both bus lines are first brought into the clock domain through a two-flop synchroniser. On every rising edge of the synchronised clock line, the block looks at the data line, but only while its own requested data level is 1 (released). If the line reads low at that moment, another master is driving it and arbitration is lost. The block then releases both lines at once and records whether the loss happened during an address transfer or a data transfer. A loss during a data transfer also raises a retry indication, because that byte must be sent again later.

The flag, the stage and the released lines persist until the sequencer pulses the clear input. The state machine has two states. `ST_TRACK` mirrors the requested levels onto the pads and watches for a loss; its transition on a detected loss is named `GO_LOST`. `ST_LOST` keeps both pads released and ignores all new losses; its transition on the clear strobe is named `GO_TRACK`. Reset enters `ST_TRACK`.

Top module: `arb_guard`

## Requirements
- R1: In `ST_TRACK`, `sda_oe` equals the inverse of `req_sda`: `sda_oe`=1 drives the line low for a requested 0, and `sda_oe`=0 releases it for a requested 1.
- R2: In `ST_TRACK`, `scl_oe` equals the inverse of `req_scl`, with the same drive-low and release rule as the data line.
- R3: A loss is detected when three conditions meet: the synchronised `scl_in` rises, `req_sda` is 1, and the synchronised `sda_in` is 0. `lost` goes to 1 three clock edges after both bus inputs settle in that pattern.
- R4: No loss is detected while `req_sda` is 0, even when `sda_in` reads low at a clock rise.
- R5: No loss is detected when `sda_in` reads high at a clock rise.
- R6: Without a rising edge on `scl_in`, a low `sda_in` does not cause a loss, whether `scl_in` is held high or held low.
- R7: While `lost` is 1, `sda_oe` and `scl_oe` are both 0, whatever `req_sda` and `req_scl` ask for.
- R8: On a loss, `lost_stage` captures `stage_data`: 0 means the address stage and 1 means the data stage.
- R9: `retry_needed` is 1 exactly when `lost` is 1 and `lost_stage` is 1 (data stage).
- R10: While `lost` is 1 and `clr` is 0, `lost` stays 1 and `lost_stage` does not change, even if a new loss condition occurs.
- R11: `clr` while `lost` is 1 returns the block to `ST_TRACK` on the next edge, with `lost` and `lost_stage` both 0. In `ST_TRACK`, `clr` has no effect.
- R12: After reset, `lost`, `lost_stage` and `retry_needed` are 0, and the outputs follow R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sda | input | 1 | Requested data line level (1 = release) |
| req_scl | input | 1 | Requested clock line level (1 = release) |
| sda_in | input | 1 | Data line as seen at the pad, asynchronous |
| scl_in | input | 1 | Clock line as seen at the pad, asynchronous |
| stage_data | input | 1 | Current transfer stage: 0 address, 1 data |
| clr | input | 1 | Clears a recorded loss |
| sda_oe | output | 1 | Data pad low-driver enable |
| scl_oe | output | 1 | Clock pad low-driver enable |
| lost | output | 1 | Arbitration has been lost |
| lost_stage | output | 1 | Stage of the recorded loss: 0 address, 1 data |
| retry_needed | output | 1 | Loss was in the data stage; the byte must be re-sent |

## Verification
The detector is swept over every combination of requested data level, sampled data level and stage, each time with a clean clock rise. This separates a real loss (release requested, line low) from the two harmless cases: we drive the line low ourselves, or the line is high. It also confirms that the stage and retry outputs follow the stage input only when a loss occurs. Further patterns hold the clock line steady while the data line is pulled low, which shows that detection depends on the edge and not on the level. A second loss is forced in the opposite stage while a first one is pending, which shows that the first record is kept. During a loss, the requested levels are toggled to show that the pads stay released.

// File: rtl/arb_guard_pkg.sv
package arb_guard_pkg;
    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_LOST  = 1'b1
    } arb_state_e;

    typedef enum logic {
        STAGE_ADDR = 1'b0,
        STAGE_DATA = 1'b1
    } arb_stage_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int           WIDTH     = 2,
    parameter int           STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_rise,
    input  logic req_sda,
    input  logic req_scl,
    input  logic stage_data,
    input  logic clr,
    output logic sda_oe,
    output logic scl_oe,
    output logic lost,
    output logic lost_stage,
    output logic retry_needed
);
    arb_state_e state_q, state_d;
    arb_stage_e stage_q;
    logic       go_lost;

    // a released data line that reads low at a clock rise means another master won
    assign go_lost = scl_rise && req_sda && !sda_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: if (go_lost) state_d = ST_LOST;   // GO_LOST
            ST_LOST:  if (clr)     state_d = ST_TRACK;  // GO_TRACK
            default:               state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            stage_q <= STAGE_ADDR;
        end else begin
            state_q <= state_d;
            if (state_q == ST_TRACK && go_lost)
                stage_q <= arb_stage_e'(stage_data);
            else if (state_q == ST_LOST && clr)
                stage_q <= STAGE_ADDR;
        end
    end

    always_comb begin
        sda_oe       = 1'b0;
        scl_oe       = 1'b0;
        lost         = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                sda_oe = !req_sda;
                scl_oe = !req_scl;
            end
            ST_LOST: lost = 1'b1;
            default: lost = 1'b0;
        endcase
        lost_stage   = (stage_q == STAGE_DATA);
        retry_needed = lost && (stage_q == STAGE_DATA);
    end
endmodule

// File: rtl/arb_guard.sv
module arb_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sda,
    input  logic req_scl,
    input  logic sda_in,
    input  logic scl_in,
    input  logic stage_data,
    input  logic clr,
    output logic sda_oe,
    output logic scl_oe,
    output logic lost,
    output logic lost_stage,
    output logic retry_needed
);
    localparam int LINES = 2;

    logic [LINES-1:0] bus_s;
    logic             scl_prev;
    logic             scl_rise;

    bus_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev <= 1'b1;
        else        scl_prev <= bus_s[1];
    end

    assign scl_rise = bus_s[1] && !scl_prev;

    arb_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (bus_s[0]),
        .scl_rise     (scl_rise),
        .req_sda      (req_sda),
        .req_scl      (req_scl),
        .stage_data   (stage_data),
        .clr          (clr),
        .sda_oe       (sda_oe),
        .scl_oe       (scl_oe),
        .lost         (lost),
        .lost_stage   (lost_stage),
        .retry_needed (retry_needed)
    );
endmodule

// File: rtl/arb_guard_chk.sv
module arb_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic req_sda,
    input logic req_scl,
    input logic clr,
    input logic sda_oe,
    input logic scl_oe,
    input logic lost,
    input logic lost_stage,
    input logic retry_needed
);
    assert_track_sda_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lost |-> (sda_oe == !req_sda));

    assert_track_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lost |-> (scl_oe == !req_scl));

    assert_loss_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(req_sda));

    assert_release_when_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (!sda_oe && !scl_oe));

    assert_retry_only_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_needed |-> (lost && lost_stage));

    assert_hold_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !clr) |=> (lost && $stable(lost_stage)));

    assert_clear_record_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && clr) |=> (!lost && !lost_stage));
endmodule

bind arb_guard arb_guard_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_sda      (req_sda),
    .req_scl      (req_scl),
    .clr          (clr),
    .sda_oe       (sda_oe),
    .scl_oe       (scl_oe),
    .lost         (lost),
    .lost_stage   (lost_stage),
    .retry_needed (retry_needed)
);

// File: tb/arb_guard_tb_top.sv
module arb_guard_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_sda = 1'b1, req_scl = 1'b1, sda_in = 1'b1, scl_in = 1'b0;
    logic stage_data = 1'b0, clr = 1'b0;
    logic sda_oe, scl_oe, lost, lost_stage, retry_needed;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    arb_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_sda(req_sda), .req_scl(req_scl),
        .sda_in(sda_in), .scl_in(scl_in), .stage_data(stage_data), .clr(clr),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .lost(lost), .lost_stage(lost_stage),
        .retry_needed(retry_needed)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1; step(1); clr = 1'b0; step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R12 reset state
        chk("R12 lost", lost, 1'b0);
        chk("R12 lost_stage", lost_stage, 1'b0);
        chk("R12 retry", retry_needed, 1'b0);

        // R1 R2 drive mapping sweep
        for (int v = 0; v < 4; v++) begin
            req_sda = v[0]; req_scl = v[1]; step(1);
            chk("R1 sda_oe", sda_oe, !v[0]);
            chk("R2 scl_oe", scl_oe, !v[1]);
        end

        // R3 R4 R5 R8 R9 sweep over stage x requested x sampled
        for (int v = 0; v < 8; v++) begin
            logic st, rq, sd, exp_lost;
            st = v[0]; rq = v[1]; sd = v[2];
            exp_lost = rq && !sd;
            scl_in = 1'b0; req_scl = 1'b1; step(4);
            do_clear();
            stage_data = st; req_sda = rq; sda_in = sd; step(4);
            chk("R6 no edge yet", lost, 1'b0);
            scl_in = 1'b1; step(4);
            chk(exp_lost ? "R3 loss" : (rq ? "R5 high line" : "R4 driving low"), lost, exp_lost);
            chk("R8 lost_stage", lost_stage, exp_lost && st);
            chk("R9 retry", retry_needed, exp_lost && st);
            if (exp_lost) begin
                // R7 requested levels have no effect while lost
                for (int w = 0; w < 4; w++) begin
                    req_sda = w[0]; req_scl = w[1]; step(1);
                    chk("R7 sda_oe", sda_oe, 1'b0);
                    chk("R7 scl_oe", scl_oe, 1'b0);
                end
            end
        end

        // R6 SCL held high, SDA falls with release requested
        scl_in = 1'b0; req_sda = 1'b1; sda_in = 1'b1; step(4);
        do_clear();
        scl_in = 1'b1; step(4);
        sda_in = 1'b0; step(6);
        chk("R6 scl held high", lost, 1'b0);
        scl_in = 1'b0; step(6);
        chk("R6 scl held low", lost, 1'b0);

        // R10 second loss in data stage ignored while address loss pending
        stage_data = 1'b0; scl_in = 1'b1; step(4);
        chk("R10 first loss", lost, 1'b1);
        chk("R10 first stage", lost_stage, 1'b0);
        stage_data = 1'b1; req_sda = 1'b1; scl_in = 1'b0; step(4);
        scl_in = 1'b1; step(4);
        chk("R10 still lost", lost, 1'b1);
        chk("R10 stage kept", lost_stage, 1'b0);
        chk("R10 no retry", retry_needed, 1'b0);

        // R11 clear
        req_sda = 1'b0; req_scl = 1'b1;
        clr = 1'b1; step(1); clr = 1'b0;
        chk("R11 lost cleared", lost, 1'b0);
        chk("R11 stage cleared", lost_stage, 1'b0);
        chk("R11 sda_oe back", sda_oe, 1'b1);
        // R11 clr in track state has no effect on a later loss
        scl_in = 1'b0; step(4);
        clr = 1'b1; step(1); clr = 1'b0;
        req_sda = 1'b1; stage_data = 1'b1; scl_in = 1'b1; step(4);
        chk("R11 new loss after clear", lost, 1'b1);
        chk("R9 retry data stage", retry_needed, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule